// File: doc/BRIEF.md
# Divider Setting Loader

This block owns the three settings a frequency synthesizer needs from its control pins: a 9-bit feedback multiplier (M), a 2-bit output-divider select (N) and a 2-bit test-select code (T). Two paths can write them. The parallel path takes M and N straight from dedicated pins. The serial path shifts a 14-slot frame in on a data pin under a slow strobe, then commits it with a load strobe. All pins are treated as asynchronous and sampled by one fast system clock. Every edge is detected on the synchronized copies, so the rest of the chip sees settings that change only on system-clock edges.

The mode pin `par_load_n` selects the path. While it is low, the parallel pins flow through to the settings. When it rises, the last value seen is kept, and serial activity may then replace it. The `ser_mode` output tells a downstream test multiplexer which path is active.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low, the settings are M=32, N=0, T=0 and `ser_mode` is 0. The shift register is cleared.
- R2: While `par_load_n` is low, `m_val`/`n_sel` follow `par_m`/`par_n` and `t_sel` is 0. A pin change shows at the outputs after the third rising clock edge that follows it.
- R3: After `par_load_n` rises, later changes on `par_m`/`par_n` have no effect on the outputs.
- R4: In serial mode, each synchronized rising edge of `ser_clk` shifts `ser_dat` in. The frame's first slot ends in T[1], followed in order by T[0], one empty slot, N[1], N[0] and M[8] down to M[0].
- R5: The value carried in the empty slot never reaches any output.
- R6: A rising edge of `ser_load` in serial mode copies the shift-register fields to the settings. Its falling edge leaves them unchanged.
- R7: While `ser_load` stays high in serial mode, every rising edge of `ser_clk` copies the just-shifted contents to the settings.
- R8: Shifting with `ser_load` low leaves the settings unchanged.
- R9: `ser_mode` equals the synchronized level of `par_load_n`: 1 is serial and 0 is parallel.
- R10: When a rising edge of `ser_clk` and a rising edge of `ser_load` are seen in the same cycle, the commit takes the contents that include the new bit.
- R11: A fall of `par_load_n` returns to the parallel path and overrides serially loaded values.
- R12: In parallel mode, `ser_clk` edges do not change the shift register. A later serial commit with no new shifts delivers the old frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Mode pin: low means parallel pass-through; the rise latches |
| par_m | input | 9 | Parallel multiplier pins |
| par_n | input | 2 | Parallel output-divider select pins |
| ser_clk | input | 1 | Serial shift strobe |
| ser_dat | input | 1 | Serial data |
| ser_load | input | 1 | Serial commit strobe |
| m_val | output | 9 | Multiplier setting |
| n_sel | output | 2 | Output-divider select |
| t_sel | output | 2 | Test-select code |
| ser_mode | output | 1 | 1 when the serial path is active |

## Verification
A shift and a commit can land on the same system-clock cycle. This happens when the synchronized `ser_clk` rise and the synchronized `ser_load` rise arrive together, or on every strobe while `ser_load` is held high. The bench provokes the first case by raising both pins at the same moment. It provokes the second by streaming a full frame with `ser_load` high. In both cases, the result is judged against a bench shift model that has already taken the new bit, so a commit of the stale contents shows as a miscompare.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int NULL_W  = 1;
  localparam int FRAME_W = T_W + NULL_W + N_W + M_W;
  localparam int M_DEFAULT = 32;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{t: '0, n: '0, m: M_W'(M_DEFAULT)};
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/divcfg_shifter.sv
module divcfg_shifter
  import divcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ser_mode,
  input  logic clk_rise,
  input  logic sd,
  output cfg_t ser_cfg
);
  localparam int N_LO = M_W;
  localparam int T_LO = M_W + N_W + NULL_W;

  logic [FRAME_W-1:0] frame_q, frame_nxt;
  logic               shift_en;

  always_comb begin
    shift_en  = ser_mode & clk_rise;
    frame_nxt = frame_q;
    if (shift_en) frame_nxt = {frame_q[FRAME_W-2:0], sd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (shift_en) frame_q <= frame_nxt;
  end

  // Field decode skips the empty slot between T and N.
  assign ser_cfg.m = frame_nxt[M_W-1:0];
  assign ser_cfg.n = frame_nxt[N_LO +: N_W];
  assign ser_cfg.t = frame_nxt[T_LO +: T_W];

  // R4: the newest slot holds the data sampled at the strobe
  a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && clk_rise) |=> frame_q[0] == $past(sd));

  // R12: parallel mode never disturbs the shift register
  a_r12_par_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode |=> $stable(frame_q));
endmodule

// File: rtl/divcfg_settings.sv
module divcfg_settings
  import divcfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ser_mode,
  input  logic load_hi,
  input  logic load_rise,
  input  logic clk_rise,
  input  cfg_t par_cfg,
  input  cfg_t ser_cfg,
  output cfg_t cfg_q
);
  logic cfg_en;
  cfg_t cfg_d;

  always_comb begin
    cfg_en = 1'b0;
    cfg_d  = cfg_q;
    if (!ser_mode) begin
      cfg_en = 1'b1;
      cfg_d  = par_cfg;
    end else if (load_hi && (load_rise || clk_rise)) begin
      cfg_en = 1'b1;
      cfg_d  = ser_cfg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_DEFAULT;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // R2: parallel pass-through
  a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_mode |=> cfg_q == $past(par_cfg));

  // R8: serial shifting without load keeps settings
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && !load_hi) |=> $stable(cfg_q));

  // R6: commit on load rise takes the shifter's test field
  a_r6_commit_t: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && load_rise) |=> cfg_q.t == $past(ser_cfg.t));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           ser_load,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_sel,
  output logic [T_W-1:0] t_sel,
  output logic           ser_mode
);
  localparam int CTRL_W = 3;
  localparam int DATA_W = 1 + M_W + N_W;

  logic [CTRL_W-1:0] ctrl_s;
  logic [DATA_W-1:0] data_s;
  logic pl_s, sc_s, sl_s, sd_s;
  logic sc_q, sl_q;
  logic clk_rise, load_rise;
  cfg_t par_cfg, ser_cfg, cfg_q;

  divcfg_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({par_load_n, ser_clk, ser_load}), .q(ctrl_s));

  // Data pins get the same delay, so they stay aligned with the strobes.
  divcfg_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_data_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_dat, par_n, par_m}), .q(data_s));

  assign {pl_s, sc_s, sl_s} = ctrl_s;
  assign sd_s               = data_s[DATA_W-1];
  assign par_cfg.m          = data_s[M_W-1:0];
  assign par_cfg.n          = data_s[M_W +: N_W];
  assign par_cfg.t          = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= 1'b0;
      sl_q <= 1'b0;
    end else begin
      sc_q <= sc_s;
      sl_q <= sl_s;
    end
  end

  assign clk_rise  = sc_s & ~sc_q;
  assign load_rise = sl_s & ~sl_q;

  divcfg_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .ser_mode(pl_s), .clk_rise(clk_rise),
    .sd(sd_s), .ser_cfg(ser_cfg));

  divcfg_settings u_set (
    .clk(clk), .rst_n(rst_n), .ser_mode(pl_s), .load_hi(sl_s),
    .load_rise(load_rise), .clk_rise(clk_rise),
    .par_cfg(par_cfg), .ser_cfg(ser_cfg), .cfg_q(cfg_q));

  assign m_val    = cfg_q.m;
  assign n_sel    = cfg_q.n;
  assign t_sel    = cfg_q.t;
  assign ser_mode = pl_s;
endmodule

// File: tb/divcfg_loader_bench.sv
module divcfg_loader_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic par_load_n, ser_clk, ser_dat, ser_load;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic [8:0] m_val;
  logic [1:0] n_sel, t_sel;
  logic ser_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [13:0] shr = '0;
  logic [12:0] exp_cfg;

  always #5 clk = ~clk;

  divcfg_loader u_divcfg_loader (
    .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m),
    .par_n(par_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_load(ser_load), .m_val(m_val), .n_sel(n_sel), .t_sel(t_sel),
    .ser_mode(ser_mode));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [12:0] exp);
    logic [12:0] act;
    act = {t_sel, n_sel, m_val};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_mode(input string req, input logic exp);
    checks++;
    if (ser_mode !== exp) begin
      fails++;
      $display("FAIL %s: ser_mode got %b expected %b", req, ser_mode, exp);
    end
  endtask

  function automatic logic [12:0] decode(input logic [13:0] w);
    return {w[13:12], w[10:9], w[8:0]};
  endfunction

  // One strobe; 'model' says whether the bench shift model takes the bit.
  task automatic send_bit(input logic b, input bit model);
    ser_dat = b;
    tick(3);
    ser_clk = 1'b1;
    if (model) shr = {shr[12:0], b};
    tick(4);
    ser_clk = 1'b0;
    tick(3);
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; par_load_n = 1'b0; par_m = 9'd32; par_n = 2'd0;
    ser_clk = 1'b0; ser_dat = 1'b0; ser_load = 1'b0;
    tick(3);
    check("R1 reset settings", {2'd0, 2'd0, 9'd32});
    check_mode("R1 reset mode", 1'b0);
    rst_n = 1'b1;
    tick(4);

    // R2: exhaustive parallel sweep
    for (int n = 0; n < 4; n++) begin
      for (int m = 0; m < 512; m++) begin
        par_m = 9'(m); par_n = 2'(n);
        tick(4);
        check("R2 parallel follow", {2'd0, 2'(n), 9'(m)});
      end
    end
    check_mode("R9 parallel flag", 1'b0);

    // R3: latch on rise of par_load_n
    par_m = 9'h155; par_n = 2'd2;
    tick(4);
    par_load_n = 1'b1;
    tick(4);
    check_mode("R9 serial flag", 1'b1);
    par_m = 9'h0AA; par_n = 2'd1;
    tick(4);
    exp_cfg = {2'd0, 2'd2, 9'h155};
    check("R3 latched ignores pins", exp_cfg);

    // R4/R5/R6/R8: serial frames sweep
    for (int k = 0; k < 64; k++) begin
      logic [13:0] w;
      w = {2'((k >> 2) % 4), 1'(k & 1), 2'(k % 4), 9'((k * 37 + 5) % 512)};
      for (int i = 13; i >= 0; i--) send_bit(w[i], 1'b1);
      check("R8 shift without load", exp_cfg);
      ser_load = 1'b1;
      tick(4);
      exp_cfg = decode(w);
      check("R4 R5 serial commit", exp_cfg);
      ser_load = 1'b0;
      tick(4);
      check("R6 load fall holds", exp_cfg);
    end

    // R7: pass-through with load held high
    ser_load = 1'b1;
    tick(4);
    for (int i = 13; i >= 0; i--) begin
      logic [13:0] w2;
      w2 = 14'h2B6D;
      send_bit(w2[i], 1'b1);
      check("R7 pass-through", decode(shr));
    end
    ser_load = 1'b0;
    tick(4);
    exp_cfg = decode(shr);

    // R10: strobe and load rise together
    for (int i = 13; i >= 1; i--) begin
      logic [13:0] w3;
      w3 = 14'h1C93;
      send_bit(w3[i], 1'b1);
    end
    check("R8 no commit before load", exp_cfg);
    ser_dat = 1'b0;
    tick(3);
    ser_clk = 1'b1; ser_load = 1'b1;
    shr = {shr[12:0], 1'b0};
    tick(4);
    exp_cfg = decode(shr);
    check("R10 coincident commit", exp_cfg);
    ser_clk = 1'b0; ser_load = 1'b0;
    tick(4);

    // R11: back to parallel overrides serial value
    par_load_n = 1'b0; par_m = 9'd77; par_n = 2'd3;
    tick(4);
    check("R11 parallel override", {2'd0, 2'd3, 9'd77});
    check_mode("R9 parallel again", 1'b0);

    // R12: strobes in parallel mode do not shift
    for (int i = 0; i < 5; i++) send_bit(1'(i & 1) ^ 1'b1, 1'b0);
    check("R12 parallel ignores strobes", {2'd0, 2'd3, 9'd77});
    par_load_n = 1'b1;
    tick(4);
    ser_load = 1'b1;
    tick(4);
    check("R12 old frame delivered", decode(shr));
    ser_load = 1'b0;
    tick(4);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule